// File: doc/BRIEF.md
# SDRAM Data-Mask Pipeline

This block sits on the data side of a single-data-rate SDRAM device model. It applies the per-beat data-mask bit with two different latencies. On writes the mask acts in the same cycle as the write data and stops that word from reaching the storage array. On reads the mask acts two cycles after it is sampled and turns off the output driver for that beat. The mask is sampled only on the rising clock edge and has no asynchronous path.

The surrounding device logic supplies flags that show whether a read burst or a write burst beat is in progress. It also supplies the write word from the pins and the word the array returns for the current read beat. The block returns a qualified array write strobe with its data word, and a read data word with an output-enable. Both outputs are registered. The array sees the strobe one edge after the write beat is sampled. When the output-enable is low, the read data output keeps its last value, so a masked beat behaves as a released bus and is not forced to zero.

Top module: `dqm_mask_pipe`

## Requirements
- R1: While `rst` is high at a rising edge, `arr_we` and `dq_oe` go to 0, `arr_wr_data` and `dq_out` go to 0, and the stored read-mask history is cleared.
- R2: After each rising edge outside reset, `arr_we` equals `wr_burst AND NOT mask_in` as sampled at that edge.
- R3: A write beat sampled with `mask_in` high, or any edge with `wr_burst` low, leaves `arr_wr_data` unchanged.
- R4: A write beat sampled with `mask_in` low puts the sampled `wr_data_in` on `arr_wr_data` after that edge.
- R5: After a rising edge, `dq_oe` equals `rd_burst` sampled at that edge AND NOT `mask_in` sampled one edge earlier. A mask driven in cycle N therefore blanks the read beat seen in cycle N+2.
- R6: When a read beat is masked, `dq_out` keeps its previous value. When the beat is not masked, `dq_out` takes the `arr_rd_data` sampled at that edge.
- R7: While `rd_burst` is low, `dq_oe` stays 0 whatever the value of `mask_in`.
- R8: A mask that is high while reset is applied has no effect on the first read beat after reset.
- R9: When a write burst is cut short by a read, raising `mask_in` on the remaining write beats keeps every one of them from the array. The mask on those beats does not blank read beats whose own mask cycle was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mask_in | input | 1 | Data-mask bit from the pins |
| rd_burst | input | 1 | A read beat is due on the output this cycle |
| wr_burst | input | 1 | A write beat is on the input this cycle |
| wr_data_in | input | DW | Write word from the pins |
| arr_rd_data | input | DW | Word returned by the array for the current read beat |
| arr_we | output | 1 | Qualified array write strobe |
| arr_wr_data | output | DW | Word to write into the array |
| dq_out | output | DW | Read word toward the pins |
| dq_oe | output | 1 | Output driver enable for `dq_out` |

## Verification
On every cycle, the assertions check the write strobe and write data against the same-cycle mask. They also check that the output-enable follows the read flag and the mask from one edge earlier, and that the read word holds whenever the driver is off. Some behaviour is visible only in the bench's scenarios. One case is a mask left high across reset that must not blank the first read after reset. Another is a write burst truncated by a read, where masked trailing write beats overlap unmasked read beats. A third is long mixed patterns, where a mistaken mask delay of one or three cycles shows up as the wrong beat being blanked.

// File: rtl/dqm_pkg.sv
package dqm_pkg;
  // a beat passes when its burst flag is set and its mask is clear
  function automatic logic beat_pass(input logic active, input logic mask);
    return active & ~mask;
  endfunction
endpackage

// File: rtl/dqm_delay.sv
module dqm_delay #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] sr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sr[0] <= 1'b0;
        else     sr[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sr[i] <= 1'b0;
        else     sr[i] <= sr[i-1];
      end
    end
  end

  assign q = sr[DEPTH-1];
endmodule

// File: rtl/dqm_wr_gate.sv
module dqm_wr_gate
  import dqm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mask,
  input  logic          active,
  input  logic [DW-1:0] din,
  output logic          we,
  output logic [DW-1:0] dout
);
  logic pass;
  assign pass = beat_pass(active, mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      we   <= 1'b0;
      dout <= '0;
    end else begin
      we <= pass;
      if (pass) dout <= din;
    end
  end
endmodule

// File: rtl/dqm_rd_gate.sv
module dqm_rd_gate
  import dqm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mask_dly,
  input  logic          active,
  input  logic [DW-1:0] din,
  output logic          oe,
  output logic [DW-1:0] dout
);
  logic pass;
  assign pass = beat_pass(active, mask_dly);

  always_ff @(posedge clk) begin
    if (rst) begin
      oe   <= 1'b0;
      dout <= '0;
    end else begin
      oe <= pass;
      if (pass) dout <= din;
    end
  end
endmodule

// File: rtl/dqm_mask_pipe.sv
module dqm_mask_pipe #(
  parameter int DW     = 16,
  parameter int RD_LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mask_in,
  input  logic          rd_burst,
  input  logic          wr_burst,
  input  logic [DW-1:0] wr_data_in,
  input  logic [DW-1:0] arr_rd_data,
  output logic          arr_we,
  output logic [DW-1:0] arr_wr_data,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  // the output register supplies the last stage of the read latency
  localparam int PRE_STAGES = RD_LAT - 1;

  logic mask_dly;

  dqm_delay #(.DEPTH(PRE_STAGES)) u_dly (
    .clk (clk),
    .rst (rst),
    .d   (mask_in),
    .q   (mask_dly)
  );

  dqm_wr_gate #(.DW(DW)) u_wr (
    .clk    (clk),
    .rst    (rst),
    .mask   (mask_in),
    .active (wr_burst),
    .din    (wr_data_in),
    .we     (arr_we),
    .dout   (arr_wr_data)
  );

  dqm_rd_gate #(.DW(DW)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .mask_dly (mask_dly),
    .active   (rd_burst),
    .din      (arr_rd_data),
    .oe       (dq_oe),
    .dout     (dq_out)
  );
endmodule

// File: rtl/dqm_mask_chk.sv
module dqm_mask_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mask_in,
  input logic          rd_burst,
  input logic          wr_burst,
  input logic [DW-1:0] wr_data_in,
  input logic          arr_we,
  input logic [DW-1:0] arr_wr_data,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe
);
  // R2
  we_on_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_burst && !mask_in) |=> arr_we);
  // R2
  we_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_burst || mask_in) |=> !arr_we);
  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_burst || mask_in) |=> $stable(arr_wr_data));
  // R4
  wr_data_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_burst && !mask_in) |=> (arr_wr_data == $past(wr_data_in)));
  // R5
  rd_mask_chk: assert property (@(posedge clk) disable iff (rst)
    mask_in |=> ##1 !dq_oe);
  // R7
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_burst |=> !dq_oe);
  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dq_oe |-> $stable(dq_out));
endmodule

bind dqm_mask_pipe dqm_mask_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mask_in     (mask_in),
  .rd_burst    (rd_burst),
  .wr_burst    (wr_burst),
  .wr_data_in  (wr_data_in),
  .arr_we      (arr_we),
  .arr_wr_data (arr_wr_data),
  .dq_out      (dq_out),
  .dq_oe       (dq_oe)
);

// File: tb/sim_dqm_mask_pipe.sv
`timescale 1ns/1ps
module sim_dqm_mask_pipe;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mask_in = 1'b0;
  logic          rd_burst = 1'b0;
  logic          wr_burst = 1'b0;
  logic [DW-1:0] wr_data_in = '0;
  logic [DW-1:0] arr_rd_data = '0;
  logic          arr_we;
  logic [DW-1:0] arr_wr_data;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int n_chk  = 0;
  int n_fail = 0;

  // expected state, derived from the requirements
  logic          prev_mask;
  logic          e_we, e_oe;
  logic [DW-1:0] e_wd, e_rq;

  always #2 clk = ~clk;

  dqm_mask_pipe #(.DW(DW), .RD_LAT(2)) u0 (
    .clk(clk), .rst(rst), .mask_in(mask_in), .rd_burst(rd_burst),
    .wr_burst(wr_burst), .wr_data_in(wr_data_in), .arr_rd_data(arr_rd_data),
    .arr_we(arr_we), .arr_wr_data(arr_wr_data), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic m);
    rst = 1'b1; mask_in = m; rd_burst = 1'b0; wr_burst = 1'b0;
    step(); step();
    prev_mask = 1'b0; e_we = 1'b0; e_oe = 1'b0; e_wd = '0; e_rq = '0;
    chk("R1 we", {31'd0, arr_we}, 32'd0);
    chk("R1 oe", {31'd0, dq_oe}, 32'd0);
    chk("R1 wdata", {16'd0, arr_wr_data}, 32'd0);
    chk("R1 rdata", {16'd0, dq_out}, 32'd0);
    rst = 1'b0;
  endtask

  // one beat: drive, clock, compare against the requirement model
  task automatic beat(input string tag, input logic m, input logic ra, input logic wa,
                      input logic [DW-1:0] wd, input logic [DW-1:0] rd);
    mask_in = m; rd_burst = ra; wr_burst = wa; wr_data_in = wd; arr_rd_data = rd;
    step();
    e_we = wa & ~m;
    if (e_we) e_wd = wd;
    e_oe = ra & ~prev_mask;
    if (e_oe) e_rq = rd;
    prev_mask = m;
    chk({tag, " we"},    {31'd0, arr_we},      {31'd0, e_we});
    chk({tag, " wdata"}, {16'd0, arr_wr_data}, {16'd0, e_wd});
    chk({tag, " oe"},    {31'd0, dq_oe},       {31'd0, e_oe});
    chk({tag, " rdata"}, {16'd0, dq_out},      {16'd0, e_rq});
  endtask

  task automatic t_write();
    beat("R4", 1'b0, 1'b0, 1'b1, 16'h1111, 16'h0);
    beat("R3", 1'b1, 1'b0, 1'b1, 16'h2222, 16'h0);
    beat("R4", 1'b0, 1'b0, 1'b1, 16'h3333, 16'h0);
    beat("R2", 1'b0, 1'b0, 1'b0, 16'h4444, 16'h0);
    beat("R3", 1'b1, 1'b0, 1'b1, 16'h5555, 16'h0);
    beat("R2", 1'b0, 1'b0, 1'b0, 16'h0, 16'h0);
  endtask

  task automatic t_read();
    beat("R5", 1'b0, 1'b1, 1'b0, 16'h0, 16'hA001);
    beat("R5", 1'b1, 1'b1, 1'b0, 16'h0, 16'hA002);
    beat("R6", 1'b0, 1'b1, 1'b0, 16'h0, 16'hA003);
    beat("R5", 1'b0, 1'b1, 1'b0, 16'h0, 16'hA004);
    beat("R5", 1'b1, 1'b1, 1'b0, 16'h0, 16'hA005);
    beat("R6", 1'b1, 1'b1, 1'b0, 16'h0, 16'hA006);
    beat("R6", 1'b0, 1'b1, 1'b0, 16'h0, 16'hA007);
    beat("R5", 1'b0, 1'b1, 1'b0, 16'h0, 16'hA008);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 6; i++)
      beat("R7", i[0], 1'b0, 1'b0, 16'h0, 16'hBEEF);
  endtask

  task automatic t_reset_mask();
    do_reset(1'b1);
    beat("R8", 1'b0, 1'b1, 1'b0, 16'h0, 16'hC0DE);
    chk("R8 first read driven", {31'd0, dq_oe}, 32'd1);
  endtask

  task automatic t_truncate();
    beat("R9", 1'b0, 1'b0, 1'b1, 16'hD001, 16'h0);
    beat("R9", 1'b0, 1'b0, 1'b1, 16'hD002, 16'h0);
    beat("R9", 1'b1, 1'b1, 1'b1, 16'hD003, 16'hE001);
    beat("R9", 1'b1, 1'b1, 1'b1, 16'hD004, 16'hE002);
    beat("R9", 1'b0, 1'b1, 1'b0, 16'h0,    16'hE003);
    beat("R9", 1'b0, 1'b1, 1'b0, 16'h0,    16'hE004);
    chk("R9 array kept last unmasked word", {16'd0, arr_wr_data}, 32'h0000D002);
  endtask

  initial begin
    do_reset(1'b0);
    t_write();
    t_read();
    t_idle();
    t_reset_mask();
    t_truncate();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule